// File: doc/BRIEF.md
# Boot-Mode Address Remapper

This block sits between one processor bus port and three downstream memories: application flash, system boot memory and SRAM. After reset it samples two strap inputs once. The captured value decides which memory answers in the low alias window that starts at address zero. The choices are flash, system boot memory, or a tiny hardwired four-word vector table that is used when the part boots from SRAM. Flash, system memory and SRAM also stay reachable at their own direct addresses in every mode.

The hardwired table gives an initial stack pointer and a reset vector into SRAM. The SRAM offset of that vector depends on a device-variant parameter. The table's two exception vectors have bit 0 clear, so taking either exception while it is mapped leads to a fault. When SRAM boot is selected, a read anywhere in the alias window past the table never completes. Addresses that fall outside every region get an error response in the same cycle. Until the straps are captured, every access is held off.

The bus is a simple valid/ready interface. A request is held until `cpu_ready_o` is high. The response comes from the selected target in the same cycle, with no register on the data path. Downstream ports share one offset, write-enable and write-data bus, and each port has its own select.

Top module: `boot_remap`

## Requirements
- R1: The straps are captured on the 4th rising clock edge after `rst_n` goes high. Strap values before that edge have no effect, and strap changes after it have no effect until the next reset.
- R2: In reset, and before the capture edge, `cpu_ready_o` is low and no downstream select is high.
- R3: Strap decode: `boot0_i`=0 selects flash boot; `boot0_i`=1 with `boot1_i`=0 selects system-memory boot; `boot0_i`=1 with `boot1_i`=1 selects stub (SRAM) boot.
- R4: In flash boot, an access at address A < FLASH_SIZE raises `flash_sel_o` with `mem_addr_o`=A. Ready and read data come from the flash port.
- R5: In system-memory boot, an access at A < SYS_SIZE raises `sys_sel_o` with `mem_addr_o`=A. An access at SYS_SIZE <= A < ALIAS_SIZE returns an error.
- R6: In stub boot, reads at 0x0, 0x4, 0x8 and 0xC complete with no select. They return 0x2000_5000, then (0x2000_0000 + variant offset) | 1, then 0x2000_0004, then 0x2000_0004. The variant offset is 0x108 for VARIANT 0 (low/medium density), 0x1CC for VARIANT 1 (value line) and 0x1E0 for VARIANT 2 (all others).
- R7: In stub boot, an access at 0x10 <= A < ALIAS_SIZE keeps `cpu_ready_o` low with no select.
- R8: In every mode, the direct regions map as follows, each with `mem_addr_o` = A minus the region base: flash at 0x0800_0000 (FLASH_SIZE bytes), system memory ending just below 0x1FFF_F000 (SYS_SIZE bytes), and SRAM at 0x2000_0000 (SRAM_SIZE bytes).
- R9: At most one select is high, and only while `cpu_req_i` is high. An address outside every region returns `cpu_ready_o`=1 and `cpu_err_o`=1 in the same cycle, with no select.
- R10: A write to the stub table returns an error. A write to a memory region raises its select with `mem_we_o`=1 and `mem_wdata_o` equal to `cpu_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| boot0_i | input | 1 | Primary boot strap |
| boot1_i | input | 1 | Secondary boot strap |
| cpu_req_i | input | 1 | Request valid, held until ready |
| cpu_addr_i | input | 32 | Byte address |
| cpu_we_i | input | 1 | Write enable |
| cpu_wdata_i | input | DW | Write data |
| cpu_ready_o | output | 1 | Transfer completes this cycle |
| cpu_err_o | output | 1 | Error response, valid with ready |
| cpu_rdata_o | output | DW | Read data |
| mem_addr_o | output | 32 | Offset within the selected region |
| mem_we_o | output | 1 | Write enable to the memories |
| mem_wdata_o | output | DW | Write data to the memories |
| flash_sel_o | output | 1 | Flash select |
| flash_ready_i | input | 1 | Flash ready |
| flash_rdata_i | input | DW | Flash read data |
| sys_sel_o | output | 1 | System memory select |
| sys_ready_i | input | 1 | System memory ready |
| sys_rdata_i | input | DW | System memory read data |
| sram_sel_o | output | 1 | SRAM select |
| sram_ready_i | input | 1 | SRAM ready |
| sram_rdata_i | input | DW | SRAM read data |

## Verification
The hardest case to reach is the capture edge itself: a correct and an off-by-one latch differ only in one cycle. To reach it, the stimulus keeps a request pending through the cycles after reset and checks the stall in each one. It then flips `boot1_i` in the cycle between the 3rd and 4th edges, so that only a capture on the 4th edge yields stub mode. A further reset with different straps brings up each other mode. Instances built with the other two variant values are read in stub mode to confirm their reset vectors.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  localparam int AW = 32;

  localparam int VAR_LOW_MED    = 0;
  localparam int VAR_VALUE_LINE = 1;
  localparam int VAR_OTHER      = 2;

  typedef enum logic [1:0] {
    MODE_FLASH = 2'd0,
    MODE_SYS   = 2'd1,
    MODE_STUB  = 2'd2
  } boot_mode_e;

  typedef enum logic [2:0] {
    TGT_STALL = 3'd0,
    TGT_FLASH = 3'd1,
    TGT_SYS   = 3'd2,
    TGT_SRAM  = 3'd3,
    TGT_STUB  = 3'd4,
    TGT_ERR   = 3'd5
  } target_e;

  function automatic logic [AW-1:0] variant_offset(input int variant);
    case (variant)
      VAR_LOW_MED:    return 32'h0000_0108;
      VAR_VALUE_LINE: return 32'h0000_01CC;
      default:        return 32'h0000_01E0;
    endcase
  endfunction

  function automatic boot_mode_e decode_straps(input logic b0, input logic b1);
    if (!b0)     return MODE_FLASH;
    else if (!b1) return MODE_SYS;
    else         return MODE_STUB;
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_remap_pkg::*;
#(
  parameter int LATCH_EDGE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot0_i,
  input  logic       boot1_i,
  output logic       latched_o,
  output boot_mode_e mode_o
);

  localparam int CW = $clog2(LATCH_EDGE + 1);
  localparam logic [CW-1:0] LAST = CW'(LATCH_EDGE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          latched_q, latched_d;
  boot_mode_e    mode_q, mode_d;

  always_comb begin
    cnt_en    = !latched_q;
    cnt_d     = cnt_q + 1'b1;
    latched_d = latched_q;
    mode_d    = mode_q;
    if (cnt_en && (cnt_q == LAST)) begin
      latched_d = 1'b1;
      mode_d    = decode_straps(boot0_i, boot1_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      latched_q <= 1'b0;
      mode_q    <= MODE_FLASH;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      latched_q <= latched_d;
      mode_q    <= mode_d;
    end
  end

  assign latched_o = latched_q;
  assign mode_o    = mode_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && $past(latched_q)) |-> $stable(mode_q)); // R1

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q |=> latched_q); // R1

endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
  import boot_remap_pkg::*;
#(
  parameter logic [31:0] ALIAS_SIZE = 32'h0008_0000,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [31:0] FLASH_SIZE = 32'h0008_0000,
  parameter logic [31:0] SYS_TOP    = 32'h1FFF_F000,
  parameter logic [31:0] SYS_SIZE   = 32'h0000_0800,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] SRAM_SIZE  = 32'h0000_5000,
  parameter int          STUB_WORDS = 4
) (
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          latched_i,
  input  boot_mode_e    mode_i,
  output target_e       tgt_o,
  output logic [AW-1:0] offset_o
);

  localparam logic [31:0] STUB_BYTES = 32'(STUB_WORDS * 4);
  localparam logic [31:0] SYS_BASE   = SYS_TOP - SYS_SIZE;
  localparam logic [31:0] FLASH_END  = FLASH_BASE + FLASH_SIZE;
  localparam logic [31:0] SRAM_END   = SRAM_BASE + SRAM_SIZE;

  logic in_alias, in_flash, in_sys, in_sram;

  always_comb begin
    in_alias = (addr_i < ALIAS_SIZE);
    in_flash = (addr_i >= FLASH_BASE) && (addr_i < FLASH_END);
    in_sys   = (addr_i >= SYS_BASE)   && (addr_i < SYS_TOP);
    in_sram  = (addr_i >= SRAM_BASE)  && (addr_i < SRAM_END);
  end

  always_comb begin
    tgt_o    = TGT_STALL;
    offset_o = '0;
    if (req_i && latched_i) begin
      if (in_alias) begin
        case (mode_i)
          MODE_FLASH: begin
            tgt_o    = (addr_i < FLASH_SIZE) ? TGT_FLASH : TGT_ERR;
            offset_o = addr_i;
          end
          MODE_SYS: begin
            tgt_o    = (addr_i < SYS_SIZE) ? TGT_SYS : TGT_ERR;
            offset_o = addr_i;
          end
          default: begin
            if (addr_i < STUB_BYTES) tgt_o = we_i ? TGT_ERR : TGT_STUB;
            else                     tgt_o = TGT_STALL;
            offset_o = addr_i;
          end
        endcase
      end else if (in_flash) begin
        tgt_o    = TGT_FLASH;
        offset_o = addr_i - FLASH_BASE;
      end else if (in_sys) begin
        tgt_o    = TGT_SYS;
        offset_o = addr_i - SYS_BASE;
      end else if (in_sram) begin
        tgt_o    = TGT_SRAM;
        offset_o = addr_i - SRAM_BASE;
      end else begin
        tgt_o    = TGT_ERR;
      end
    end
  end

endmodule

// File: rtl/boot_stub_rom.sv
module boot_stub_rom
  import boot_remap_pkg::*;
#(
  parameter int          VARIANT    = VAR_LOW_MED,
  parameter int          DW         = 32,
  parameter int          STUB_WORDS = 4,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] STUB_SP    = 32'h2000_5000
) (
  input  logic [$clog2(STUB_WORDS)-1:0] idx_i,
  output logic [DW-1:0]                 word_o
);

  localparam logic [31:0] RESET_VEC = (SRAM_BASE + variant_offset(VARIANT)) | 32'h1;
  localparam logic [31:0] FAULT_VEC = SRAM_BASE + 32'h4;

  logic [DW-1:0] words [STUB_WORDS];

  for (genvar i = 0; i < STUB_WORDS; i++) begin : g_word
    if (i == 0) begin : g_sp
      assign words[i] = DW'(STUB_SP);
    end else if (i == 1) begin : g_rst
      assign words[i] = DW'(RESET_VEC);
    end else begin : g_flt
      assign words[i] = DW'(FAULT_VEC);
    end
  end

  assign word_o = words[idx_i];

endmodule

// File: rtl/boot_remap.sv
module boot_remap
  import boot_remap_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          VARIANT    = VAR_LOW_MED,
  parameter int          LATCH_EDGE = 4,
  parameter int          STUB_WORDS = 4,
  parameter logic [31:0] ALIAS_SIZE = 32'h0008_0000,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter logic [31:0] FLASH_SIZE = 32'h0008_0000,
  parameter logic [31:0] SYS_TOP    = 32'h1FFF_F000,
  parameter logic [31:0] SYS_SIZE   = 32'h0000_0800,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] SRAM_SIZE  = 32'h0000_5000,
  parameter logic [31:0] STUB_SP    = 32'h2000_5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot0_i,
  input  logic          boot1_i,
  input  logic          cpu_req_i,
  input  logic [31:0]   cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic          cpu_err_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [31:0]   mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          flash_sel_o,
  input  logic          flash_ready_i,
  input  logic [DW-1:0] flash_rdata_i,
  output logic          sys_sel_o,
  input  logic          sys_ready_i,
  input  logic [DW-1:0] sys_rdata_i,
  output logic          sram_sel_o,
  input  logic          sram_ready_i,
  input  logic [DW-1:0] sram_rdata_i
);

  localparam int IW = $clog2(STUB_WORDS);
  localparam logic [31:0] STUB_BYTES = 32'(STUB_WORDS * 4);

  logic          latched;
  boot_mode_e    mode;
  target_e       tgt;
  logic [31:0]   offset;
  logic [DW-1:0] stub_word;

  boot_strap_latch #(.LATCH_EDGE(LATCH_EDGE)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot0_i   (boot0_i),
    .boot1_i   (boot1_i),
    .latched_o (latched),
    .mode_o    (mode)
  );

  boot_addr_decode #(
    .ALIAS_SIZE (ALIAS_SIZE),
    .FLASH_BASE (FLASH_BASE),
    .FLASH_SIZE (FLASH_SIZE),
    .SYS_TOP    (SYS_TOP),
    .SYS_SIZE   (SYS_SIZE),
    .SRAM_BASE  (SRAM_BASE),
    .SRAM_SIZE  (SRAM_SIZE),
    .STUB_WORDS (STUB_WORDS)
  ) u_decode (
    .req_i     (cpu_req_i),
    .addr_i    (cpu_addr_i),
    .we_i      (cpu_we_i),
    .latched_i (latched),
    .mode_i    (mode),
    .tgt_o     (tgt),
    .offset_o  (offset)
  );

  boot_stub_rom #(
    .VARIANT    (VARIANT),
    .DW         (DW),
    .STUB_WORDS (STUB_WORDS),
    .SRAM_BASE  (SRAM_BASE),
    .STUB_SP    (STUB_SP)
  ) u_stub (
    .idx_i  (offset[IW+1:2]),
    .word_o (stub_word)
  );

  assign mem_addr_o  = offset;
  assign mem_we_o    = cpu_we_i;
  assign mem_wdata_o = cpu_wdata_i;

  always_comb begin
    flash_sel_o = (tgt == TGT_FLASH);
    sys_sel_o   = (tgt == TGT_SYS);
    sram_sel_o  = (tgt == TGT_SRAM);
    cpu_ready_o = 1'b0;
    cpu_err_o   = 1'b0;
    cpu_rdata_o = '0;
    case (tgt)
      TGT_FLASH: begin cpu_ready_o = flash_ready_i; cpu_rdata_o = flash_rdata_i; end
      TGT_SYS:   begin cpu_ready_o = sys_ready_i;   cpu_rdata_o = sys_rdata_i;   end
      TGT_SRAM:  begin cpu_ready_o = sram_ready_i;  cpu_rdata_o = sram_rdata_i;  end
      TGT_STUB:  begin cpu_ready_o = 1'b1;          cpu_rdata_o = stub_word;     end
      TGT_ERR:   begin cpu_ready_o = 1'b1;          cpu_err_o   = 1'b1;          end
      default:   ;
    endcase
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_sel_o, sys_sel_o, sram_sel_o})); // R9

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_sel_o || sys_sel_o || sram_sel_o) |-> cpu_req_i); // R9

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err_o |-> cpu_ready_o); // R9

  AST_HOLD_BEFORE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> (!cpu_ready_o && !flash_sel_o && !sys_sel_o && !sram_sel_o)); // R2

  AST_STUB_TAIL_HANGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && latched && mode == MODE_STUB &&
     cpu_addr_i >= STUB_BYTES && cpu_addr_i < ALIAS_SIZE)
    |-> (!cpu_ready_o && !flash_sel_o && !sys_sel_o && !sram_sel_o)); // R7

endmodule

// File: tb/boot_remap_bench.sv
`timescale 1ns/1ps
module boot_remap_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot0 = 1'b0, boot1 = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic flash_rdy = 1'b1;

  logic        ready, err, mem_we, fsel, ssel, rsel;
  logic [31:0] rdata, maddr, mwdata;
  logic [31:0] flash_rd, sys_rd, sram_rd;

  logic        vl_ready, vl_err, vl_we, vl_f, vl_s, vl_r;
  logic [31:0] vl_rdata, vl_maddr, vl_wd;
  logic        ot_ready, ot_err, ot_we, ot_f, ot_s, ot_r;
  logic [31:0] ot_rdata, ot_maddr, ot_wd;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign flash_rd = 32'hF000_0000 | maddr;
  assign sys_rd   = 32'h5000_0000 | maddr;
  assign sram_rd  = 32'hA000_0000 | maddr;

  boot_remap u_boot_remap (
    .clk(clk), .rst_n(rst_n), .boot0_i(boot0), .boot1_i(boot1),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_we_i(we), .cpu_wdata_i(wdata),
    .cpu_ready_o(ready), .cpu_err_o(err), .cpu_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_we_o(mem_we), .mem_wdata_o(mwdata),
    .flash_sel_o(fsel), .flash_ready_i(flash_rdy), .flash_rdata_i(flash_rd),
    .sys_sel_o(ssel), .sys_ready_i(1'b1), .sys_rdata_i(sys_rd),
    .sram_sel_o(rsel), .sram_ready_i(1'b1), .sram_rdata_i(sram_rd));

  boot_remap #(.VARIANT(1)) u_boot_remap_vl (
    .clk(clk), .rst_n(rst_n), .boot0_i(boot0), .boot1_i(boot1),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_we_i(we), .cpu_wdata_i(wdata),
    .cpu_ready_o(vl_ready), .cpu_err_o(vl_err), .cpu_rdata_o(vl_rdata),
    .mem_addr_o(vl_maddr), .mem_we_o(vl_we), .mem_wdata_o(vl_wd),
    .flash_sel_o(vl_f), .flash_ready_i(1'b1), .flash_rdata_i(32'h0),
    .sys_sel_o(vl_s), .sys_ready_i(1'b1), .sys_rdata_i(32'h0),
    .sram_sel_o(vl_r), .sram_ready_i(1'b1), .sram_rdata_i(32'h0));

  boot_remap #(.VARIANT(2)) u_boot_remap_ot (
    .clk(clk), .rst_n(rst_n), .boot0_i(boot0), .boot1_i(boot1),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_we_i(we), .cpu_wdata_i(wdata),
    .cpu_ready_o(ot_ready), .cpu_err_o(ot_err), .cpu_rdata_o(ot_rdata),
    .mem_addr_o(ot_maddr), .mem_we_o(ot_we), .mem_wdata_o(ot_wd),
    .flash_sel_o(ot_f), .flash_ready_i(1'b1), .flash_rdata_i(32'h0),
    .sys_sel_o(ot_s), .sys_ready_i(1'b1), .sys_rdata_i(32'h0),
    .sram_sel_o(ot_r), .sram_ready_i(1'b1), .sram_rdata_i(32'h0));

  typedef struct {
    logic        we;
    logic [31:0] wd;
    logic        rdy;
    logic        er;
    logic [31:0] rd;
    logic [2:0]  sel;
    logic [31:0] ma;
    string       tag;
  } item_t;

  item_t sb[$];

  localparam logic [2:0] S_NONE = 3'b000, S_FL = 3'b001, S_SY = 3'b010, S_SR = 3'b100;

  // Driver: drives one request at a falling edge and queues what it should produce.
  task automatic drv(input logic [31:0] a, input logic w, input logic [31:0] wd,
                     input logic erdy, input logic eer, input logic [31:0] erd,
                     input logic [2:0] esel, input logic [31:0] ema, input string tag);
    item_t it;
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = wd;
    #2;
    it.we = w; it.wd = wd; it.rdy = erdy; it.er = eer; it.rd = erd;
    it.sel = esel; it.ma = ema; it.tag = tag;
    sb.push_back(it);
    #1;
  endtask

  // Monitor: pops expectations and compares against the live outputs.
  initial begin
    item_t it;
    logic [2:0] asel;
    bit bad;
    forever begin
      wait (sb.size() > 0);
      it = sb.pop_front();
      asel = {rsel, ssel, fsel};
      bad = 0;
      if (ready !== it.rdy) bad = 1;
      if (it.rdy && err !== it.er) bad = 1;
      if (it.rdy && !it.er && !it.we && rdata !== it.rd) bad = 1;
      if (asel !== it.sel) bad = 1;
      if (it.sel != 3'b000 && maddr !== it.ma) bad = 1;
      if (it.sel != 3'b000 && (mem_we !== it.we || mwdata !== it.wd)) bad = 1;
      compared++;
      if (bad) begin
        mismatched++;
        $display("FAIL %s: act rdy=%b err=%b rd=%h sel=%b ma=%h we=%b | exp rdy=%b err=%b rd=%h sel=%b ma=%h we=%b",
                 it.tag, ready, err, rdata, asel, maddr, mem_we,
                 it.rdy, it.er, it.rd, it.sel, it.ma, it.we);
      end
    end
  end

  task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic b0, input logic b1);
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0; boot0 = b0; boot1 = b1;
    repeat (2) @(negedge clk);
    check_word("R2 in reset ready/selects", {31'b0, ready | fsel | ssel | rsel}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    // ---------- flash boot (R3: boot0=0) ----------
    do_reset(1'b0, 1'b0);
    drv(32'h0800_0000, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall edge1");
    drv(32'h0800_0000, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall edge2");
    drv(32'h0800_0000, 0, 0, 0, 0, 0, S_NONE, 0, "R1 R2 stall edge3");
    drv(32'h0000_0004, 0, 0, 1, 0, 32'hF000_0004, S_FL, 32'h4, "R1 R4 alias flash");
    drv(32'h0007_FFFC, 0, 0, 1, 0, 32'hF007_FFFC, S_FL, 32'h7_FFFC, "R4 alias flash top");
    drv(32'h0800_0100, 0, 0, 1, 0, 32'hF000_0100, S_FL, 32'h100, "R8 direct flash");
    drv(32'h2000_0010, 0, 0, 1, 0, 32'hA000_0010, S_SR, 32'h10, "R8 direct sram");
    drv(32'h1FFF_E800, 0, 0, 1, 0, 32'h5000_0000, S_SY, 32'h0, "R8 direct sys base");
    drv(32'h1FFF_F000, 0, 0, 1, 1, 0, S_NONE, 0, "R9 past sys error");
    drv(32'h4000_0000, 0, 0, 1, 1, 0, S_NONE, 0, "R9 unmapped error");
    drv(32'h2000_0020, 1, 32'h1234_5678, 1, 0, 0, S_SR, 32'h20, "R10 sram write");
    flash_rdy = 1'b0;
    drv(32'h0000_0008, 0, 0, 0, 0, 0, S_FL, 32'h8, "R4 flash wait");
    flash_rdy = 1'b1;
    boot0 = 1'b1; boot1 = 1'b1;
    drv(32'h0000_0000, 0, 0, 1, 0, 32'hF000_0000, S_FL, 32'h0, "R1 straps ignored after latch");

    // ---------- system-memory boot (R3: boot0=1 boot1=0) ----------
    do_reset(1'b1, 1'b0);
    repeat (3) drv(32'h0, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall sys");
    drv(32'h0000_0000, 0, 0, 1, 0, 32'h5000_0000, S_SY, 32'h0, "R3 R5 alias sys");
    drv(32'h0000_07FC, 0, 0, 1, 0, 32'h5000_07FC, S_SY, 32'h7FC, "R5 alias sys top");
    drv(32'h0000_0800, 0, 0, 1, 1, 0, S_NONE, 0, "R5 alias past sys error");
    drv(32'h2000_0000, 0, 0, 1, 0, 32'hA000_0000, S_SR, 32'h0, "R8 sram in sys mode");

    // ---------- stub boot, straps change between edge 3 and edge 4 ----------
    do_reset(1'b1, 1'b0);
    drv(32'h0, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall stub e1");
    drv(32'h0, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall stub e2");
    drv(32'h0, 0, 0, 0, 0, 0, S_NONE, 0, "R2 stall stub e3");
    boot1 = 1'b1;
    drv(32'h0000_0000, 0, 0, 1, 0, 32'h2000_5000, S_NONE, 0, "R1 R3 R6 stub sp");
    drv(32'h0000_0004, 0, 0, 1, 0, 32'h2000_0109, S_NONE, 0, "R6 stub reset vec");
    check_word("R6 value-line reset vec", vl_rdata, 32'h2000_01CD);
    check_word("R6 other reset vec", ot_rdata, 32'h2000_01E1);
    drv(32'h0000_0008, 0, 0, 1, 0, 32'h2000_0004, S_NONE, 0, "R6 stub nmi vec");
    drv(32'h0000_000C, 0, 0, 1, 0, 32'h2000_0004, S_NONE, 0, "R6 stub fault vec");
    drv(32'h0000_0010, 0, 0, 0, 0, 0, S_NONE, 0, "R7 stub tail hang");
    drv(32'h0007_FFFC, 0, 0, 0, 0, 0, S_NONE, 0, "R7 stub window end hang");
    drv(32'h0000_0000, 1, 32'hDEAD_BEEF, 1, 1, 0, S_NONE, 0, "R10 stub write error");
    drv(32'h2000_0108, 0, 0, 1, 0, 32'hA000_0108, S_SR, 32'h108, "R8 sram in stub mode");
    drv(32'h0800_0000, 0, 0, 1, 0, 32'hF000_0000, S_FL, 32'h0, "R8 flash in stub mode");

    @(negedge clk);
    req = 1'b0;
    wait (sb.size() == 0);
    #1;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule